// File: doc/BRIEF.md
# Masked Event Interrupt Unit with Autopoll

This unit gathers device events into an 8-bit pending register. It drives an active-low interrupt line whenever a pending bit is also enabled in an 8-bit mask. A host talks to it through single-cycle command beats. Each beat carries a command code, an argument count of up to four bytes and the argument bytes. Every beat is answered one cycle later by a reply beat. The acknowledge command returns the pending status and clears it.

The unit also schedules polls on an attached input-device bus. The bus transaction itself is not part of the unit. A request pulse leaves the unit, and the bus later answers with a reply length and up to four data bytes. While a 16-bit device mask is nonzero, a period timer asks for a poll every `POLL_CYCLES` clocks. The default of 3,000,000 clocks is 30 ms at 100 MHz. A poll is skipped while an earlier bus reply still waits to be acknowledged. A host can also send an explicit bus request. The answer to either kind of request is kept in a reply buffer until the next acknowledge command picks it up.

Top module: `evt_irq_unit`

## Requirements
- R1: `irq_n_o` is a register. It is low exactly when (pending AND mask) is nonzero, and it takes the value of the pending and mask registers written on the same clock edge.
- R2: After reset the pending register is 0x00 and the mask is 0x81, which enables bit 0 (bus data) and bit 7 (tick). The autopoll mask `poll_mask_o` is 0, `irq_n_o` is high, and no reply or bus request is active.
- R3: Acknowledge (code 0x10) with zero arguments while pending bit 0 is set returns `1 + buffer length` bytes. Byte 0 is pending AND 0x03, and the buffered bytes follow. Only bits 0 and 1 are cleared, and the buffer is emptied.
- R4: Acknowledge with zero arguments while bit 0 is clear returns one byte, the whole pending value, and clears the whole register. An acknowledge with any nonzero argument count changes nothing and returns length 0.
- R5: Set-mask (code 0x11) with exactly one argument loads that byte into the mask. Any other argument count leaves the mask unchanged.
- R6: While the autopoll mask is nonzero, a poll request (`bus_req_o` and `bus_auto_o` high for one cycle, `bus_cmd_o` = 0x00) comes due every `POLL_CYCLES` cycles. A due poll is skipped if pending bit 0 is set or a bus transfer is outstanding. If an explicit request goes out in the same cycle, the explicit request wins and the poll is skipped. A poll answer with nonzero length sets bits 0 and 1 and buffers the raw data bytes. A poll answer of length 0 changes nothing.
- R7: A bus command (code 0x20) whose arguments 0 and 1 are 0x00 and 0x86 sets the autopoll mask to {argument 2, argument 3}, high byte first. It does so only when it carries exactly 4 arguments; with any other count it is ignored.
- R8: Writing an autopoll mask that differs from the current one restarts the period timer, so the first poll comes `POLL_CYCLES` cycles after the command edge. Writing the same value again has no effect. A zero mask, or poll-off (code 0x21) with zero arguments, clears the mask and stops polling.
- R9: A bus command with fewer than 2 arguments is ignored. Otherwise, if it has fewer than 3 arguments, or if its payload count (argument 2) exceeds the argument count minus 3, the buffer becomes the single byte 0x00 and bit 0 is set. Otherwise, when no transfer is outstanding, an explicit request goes out with `bus_cmd_o` = argument 0. Its answer buffers 0x01, the length, then the data; a zero-length answer buffers 0x00 alone. Either way the answer sets bit 0 only.
- R10: A `tick_i` pulse sets pending bit 7, and `evt_i[k]` sets pending bit k+2, regardless of the mask. A bit set on the same edge as an acknowledge clear survives.
- R11: Every command beat gives `rsp_valid_o` for one cycle on the following cycle. Only an accepted acknowledge has a nonzero `rsp_len_o`. Reply byte i sits at `rsp_data_o[8i+7:8i]`, and bytes past the length read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second tick pulse |
| evt_i | input | 5 | Device event pulses for pending bits 6..2 |
| cmd_valid_i | input | 1 | Command beat valid |
| cmd_code_i | input | 8 | Command code |
| cmd_len_i | input | 3 | Argument byte count |
| cmd_args_i | input | 32 | Argument bytes, byte i at bits 8i+7:8i |
| rsp_valid_o | output | 1 | Reply beat valid |
| rsp_len_o | output | 3 | Reply byte count |
| rsp_data_o | output | 56 | Reply bytes, byte i at bits 8i+7:8i |
| irq_n_o | output | 1 | Active-low interrupt |
| bus_req_o | output | 1 | Bus transfer request pulse |
| bus_auto_o | output | 1 | Request is an autopoll |
| bus_cmd_o | output | 8 | Device command byte of the request |
| poll_mask_o | output | 16 | Current autopoll device mask |
| dev_rsp_valid_i | input | 1 | Bus answer valid |
| dev_rsp_len_i | input | 3 | Bus answer length (0..4) |
| dev_rsp_data_i | input | 32 | Bus answer bytes, byte i at bits 8i+7:8i |

## Verification
A command, event, tick or bus answer sampled on one edge shows its effect one cycle later: the reply beat, the new pending and mask values, and the new level of `irq_n_o`. An explicit bus request pulse appears one cycle after its command. The first autopoll request appears exactly `POLL_CYCLES` cycles after the edge that loads a new mask, and later requests follow one period apart. The bench keeps a behavioural model that steps on each rising edge and compares every output on the falling edge after it, so each result is checked in the cycle it is due. A result that arrives a cycle early or late is reported.

// File: rtl/eiu_pkg.sv
package eiu_pkg;
    localparam int BIT_BUS  = 0;
    localparam int BIT_AUTO = 1;
    localparam int BIT_TICK = 7;

    localparam logic [7:0] CODE_ACK     = 8'h10;
    localparam logic [7:0] CODE_MASK    = 8'h11;
    localparam logic [7:0] CODE_BUS     = 8'h20;
    localparam logic [7:0] CODE_POLLOFF = 8'h21;
    localparam logic [7:0] APOLL_SUB    = 8'h86;
    localparam logic [7:0] MASK_RESET   = 8'h81;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ACK,
        OP_MASK,
        OP_APOLL,
        OP_POLLOFF,
        OP_BUSREQ,
        OP_BUSFAIL
    } op_e;
endpackage

// File: rtl/eiu_cmd_decode.sv
module eiu_cmd_decode
    import eiu_pkg::*;
#(
    parameter int ARG_MAX = 4,
    parameter int ALEN_W  = 3
) (
    input  logic                 valid_i,
    input  logic [7:0]           code_i,
    input  logic [ALEN_W-1:0]    len_i,
    input  logic [ARG_MAX*8-1:0] args_i,
    output op_e                  op_o,
    output logic [7:0]           mask_val_o,
    output logic [15:0]          apoll_val_o,
    output logic [7:0]           bus_cmd_o
);
    logic [7:0] len8;
    logic [7:0] a0, a1, a2, a3;

    assign len8 = 8'(len_i);
    assign a0   = args_i[7:0];
    assign a1   = args_i[15:8];
    assign a2   = args_i[23:16];
    assign a3   = args_i[31:24];

    assign mask_val_o  = a0;
    assign apoll_val_o = {a2, a3};
    assign bus_cmd_o   = a0;

    always_comb begin
        op_o = OP_NONE;
        if (valid_i) begin
            case (code_i)
                CODE_ACK:     op_o = (len8 == 8'd0) ? OP_ACK : OP_NONE;
                CODE_MASK:    op_o = (len8 == 8'd1) ? OP_MASK : OP_NONE;
                CODE_POLLOFF: op_o = (len8 == 8'd0) ? OP_POLLOFF : OP_NONE;
                CODE_BUS: begin
                    if (len8 < 8'd2) begin
                        op_o = OP_NONE;
                    end else if (a0 == 8'h00 && a1 == APOLL_SUB) begin
                        op_o = (len8 == 8'd4) ? OP_APOLL : OP_NONE;
                    end else if (len8 < 8'd3 || a2 > (len8 - 8'd3)) begin
                        op_o = OP_BUSFAIL;
                    end else begin
                        op_o = OP_BUSREQ;
                    end
                end
                default: op_o = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/eiu_poll_timer.sv
module eiu_poll_timer #(
    parameter int PERIOD = 3000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic expire_o
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart_i || !run_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/eiu_reply_pack.sv
module eiu_reply_pack
    import eiu_pkg::*;
#(
    parameter int BUF_MAX = 6,
    parameter int BLEN_W  = 3,
    parameter int RLEN_W  = 3
) (
    input  logic [7:0]               pend_i,
    input  logic [BUF_MAX*8-1:0]     buf_i,
    input  logic [BLEN_W-1:0]        buf_len_i,
    output logic [RLEN_W-1:0]        len_o,
    output logic [(BUF_MAX+1)*8-1:0] data_o
);
    logic [BUF_MAX*8-1:0] trimmed;

    for (genvar i = 0; i < BUF_MAX; i++) begin : g_trim
        assign trimmed[i*8 +: 8] = (BLEN_W'(i) < buf_len_i) ? buf_i[i*8 +: 8] : 8'h00;
    end

    always_comb begin
        if (pend_i[BIT_BUS]) begin
            data_o = {trimmed, 6'b0, pend_i[BIT_AUTO], pend_i[BIT_BUS]};
            len_o  = RLEN_W'(buf_len_i) + RLEN_W'(1);
        end else begin
            data_o = {{(BUF_MAX*8){1'b0}}, pend_i};
            len_o  = RLEN_W'(1);
        end
    end
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
    import eiu_pkg::*;
#(
    parameter int ARG_MAX     = 4,
    parameter int DEV_MAX     = 4,
    parameter int POLL_CYCLES = 3000000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_i,
    input  logic [4:0]               evt_i,
    input  logic                     cmd_valid_i,
    input  logic [7:0]               cmd_code_i,
    input  logic [2:0]               cmd_len_i,
    input  logic [ARG_MAX*8-1:0]     cmd_args_i,
    output logic                     rsp_valid_o,
    output logic [2:0]               rsp_len_o,
    output logic [(DEV_MAX+3)*8-1:0] rsp_data_o,
    output logic                     irq_n_o,
    output logic                     bus_req_o,
    output logic                     bus_auto_o,
    output logic [7:0]               bus_cmd_o,
    output logic [15:0]              poll_mask_o,
    input  logic                     dev_rsp_valid_i,
    input  logic [2:0]               dev_rsp_len_i,
    input  logic [DEV_MAX*8-1:0]     dev_rsp_data_i
);
    localparam int BUF_MAX = DEV_MAX + 2;
    localparam int RSP_MAX = BUF_MAX + 1;
    localparam int ALEN_W  = 3;
    localparam int BLEN_W  = $clog2(BUF_MAX + 1);
    localparam int RLEN_W  = 3;

    typedef struct packed {
        logic [7:0]           pend;
        logic [7:0]           mask;
        logic [15:0]          apm;
        logic                 busy;
        logic                 auto_kind;
        logic [BUF_MAX*8-1:0] rbuf;
        logic [BLEN_W-1:0]    rbuf_len;
        logic                 rsp_valid;
        logic [RLEN_W-1:0]    rsp_len;
        logic [RSP_MAX*8-1:0] rsp_data;
        logic                 req;
        logic                 req_auto;
        logic [7:0]           req_cmd;
        logic                 irq_n;
    } state_t;

    state_t s_d, s_q;

    op_e                  op;
    logic [7:0]           mask_val;
    logic [15:0]          apoll_val;
    logic [7:0]           dec_cmd;
    logic [RLEN_W-1:0]    pack_len;
    logic [RSP_MAX*8-1:0] pack_data;
    logic                 expire;
    logic                 restart;
    logic [7:0]           set_b, clr_b;
    logic [7:0]           pend_w, mask_w;

    eiu_cmd_decode #(.ARG_MAX(ARG_MAX), .ALEN_W(ALEN_W)) u_dec (
        .valid_i     (cmd_valid_i),
        .code_i      (cmd_code_i),
        .len_i       (cmd_len_i),
        .args_i      (cmd_args_i),
        .op_o        (op),
        .mask_val_o  (mask_val),
        .apoll_val_o (apoll_val),
        .bus_cmd_o   (dec_cmd)
    );

    eiu_reply_pack #(.BUF_MAX(BUF_MAX), .BLEN_W(BLEN_W), .RLEN_W(RLEN_W)) u_pack (
        .pend_i    (s_q.pend),
        .buf_i     (s_q.rbuf),
        .buf_len_i (s_q.rbuf_len),
        .len_o     (pack_len),
        .data_o    (pack_data)
    );

    eiu_poll_timer #(.PERIOD(POLL_CYCLES)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (s_q.apm != 16'h0),
        .restart_i (restart),
        .expire_o  (expire)
    );

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;
        s_d.rsp_len   = '0;
        s_d.rsp_data  = '0;
        s_d.req       = 1'b0;
        s_d.req_auto  = 1'b0;
        s_d.req_cmd   = 8'h00;
        clr_b         = 8'h00;
        set_b         = {1'b0, evt_i, 2'b00};
        if (tick_i) begin
            set_b[BIT_TICK] = 1'b1;
        end

        // host command
        if (cmd_valid_i) begin
            s_d.rsp_valid = 1'b1;
            case (op)
                OP_ACK: begin
                    s_d.rsp_len  = pack_len;
                    s_d.rsp_data = pack_data;
                    if (s_q.pend[BIT_BUS]) begin
                        clr_b[BIT_BUS]  = 1'b1;
                        clr_b[BIT_AUTO] = 1'b1;
                        s_d.rbuf_len    = '0;
                    end else begin
                        clr_b = 8'hFF;
                    end
                end
                OP_MASK:    s_d.mask = mask_val;
                OP_APOLL:   s_d.apm  = apoll_val;
                OP_POLLOFF: s_d.apm  = 16'h0;
                OP_BUSREQ: begin
                    if (!s_q.busy) begin
                        s_d.req       = 1'b1;
                        s_d.req_cmd   = dec_cmd;
                        s_d.busy      = 1'b1;
                        s_d.auto_kind = 1'b0;
                    end
                end
                OP_BUSFAIL: begin
                    s_d.rbuf        = '0;
                    s_d.rbuf_len    = BLEN_W'(1);
                    set_b[BIT_BUS]  = 1'b1;
                end
                default: ;
            endcase
        end

        // bus answer
        if (dev_rsp_valid_i && s_q.busy) begin
            s_d.busy = 1'b0;
            if (s_q.auto_kind) begin
                if (dev_rsp_len_i != 3'd0) begin
                    s_d.rbuf        = {16'h0000, dev_rsp_data_i};
                    s_d.rbuf_len    = BLEN_W'(dev_rsp_len_i);
                    set_b[BIT_BUS]  = 1'b1;
                    set_b[BIT_AUTO] = 1'b1;
                end
            end else begin
                if (dev_rsp_len_i != 3'd0) begin
                    s_d.rbuf     = {dev_rsp_data_i, 5'b0, dev_rsp_len_i, 8'h01};
                    s_d.rbuf_len = BLEN_W'(dev_rsp_len_i) + BLEN_W'(2);
                end else begin
                    s_d.rbuf     = '0;
                    s_d.rbuf_len = BLEN_W'(1);
                end
                set_b[BIT_BUS] = 1'b1;
            end
        end

        // autopoll scheduling
        restart = (s_d.apm != s_q.apm);
        if (expire && !restart && s_d.apm != 16'h0 && !s_q.pend[BIT_BUS]
            && !s_q.busy && !s_d.req) begin
            s_d.req       = 1'b1;
            s_d.req_auto  = 1'b1;
            s_d.req_cmd   = 8'h00;
            s_d.busy      = 1'b1;
            s_d.auto_kind = 1'b1;
        end

        s_d.pend  = (s_q.pend & ~clr_b) | set_b;
        s_d.irq_n = ~|(s_d.pend & s_d.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.mask  <= MASK_RESET;
            s_q.irq_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_w      = s_q.pend;
    assign mask_w      = s_q.mask;
    assign rsp_valid_o = s_q.rsp_valid;
    assign rsp_len_o   = s_q.rsp_len;
    assign rsp_data_o  = s_q.rsp_data;
    assign irq_n_o     = s_q.irq_n;
    assign bus_req_o   = s_q.req;
    assign bus_auto_o  = s_q.req_auto;
    assign bus_cmd_o   = s_q.req_cmd;
    assign poll_mask_o = s_q.apm;
endmodule

// File: rtl/eiu_checker.sv
module eiu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_i,
    input logic [4:0]  evt_i,
    input logic        cmd_valid_i,
    input logic [7:0]  cmd_code_i,
    input logic [2:0]  cmd_len_i,
    input logic [7:0]  arg0,
    input logic        dev_rsp_valid_i,
    input logic        rsp_valid_o,
    input logic        irq_n_o,
    input logic        bus_req_o,
    input logic        bus_auto_o,
    input logic [15:0] poll_mask_o,
    input logic [7:0]  pend,
    input logic [7:0]  mask
);
    logic ack_cmd;
    assign ack_cmd = cmd_valid_i && cmd_code_i == 8'h10 && cmd_len_i == 3'd0;

    assert_irq_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_o == ((pend & mask) == 8'h00));

    assert_ack_bus_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_cmd && pend[0] && !dev_rsp_valid_i) |=> (pend[1:0] == 2'b00));

    assert_ack_all_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_cmd && !pend[0] && !dev_rsp_valid_i && !tick_i && evt_i == 5'd0)
        |=> (pend == 8'h00));

    assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_code_i == 8'h11 && cmd_len_i == 3'd1) |=> (mask == $past(arg0)));

    assert_poll_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i == 1'b0 || cmd_valid_i == 1'b1) && (bus_req_o && bus_auto_o)
        |-> !$past(pend[0]));

    assert_poll_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_auto_o) |-> (poll_mask_o != 16'h0));

    assert_tick_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> pend[7]);

    assert_rsp_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_i |=> rsp_valid_o);
endmodule

bind evt_irq_unit eiu_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick_i          (tick_i),
    .evt_i           (evt_i),
    .cmd_valid_i     (cmd_valid_i),
    .cmd_code_i      (cmd_code_i),
    .cmd_len_i       (cmd_len_i),
    .arg0            (cmd_args_i[7:0]),
    .dev_rsp_valid_i (dev_rsp_valid_i),
    .rsp_valid_o     (rsp_valid_o),
    .irq_n_o         (irq_n_o),
    .bus_req_o       (bus_req_o),
    .bus_auto_o      (bus_auto_o),
    .poll_mask_o     (poll_mask_o),
    .pend            (pend_w),
    .mask            (mask_w)
);

// File: tb/tb_evt_irq_unit.sv
`timescale 1ns/1ps
module tb_evt_irq_unit;
    localparam int P = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [4:0]  evt_i = '0;
    logic        cmd_valid_i = 1'b0;
    logic [7:0]  cmd_code_i = '0;
    logic [2:0]  cmd_len_i = '0;
    logic [31:0] cmd_args_i = '0;
    logic        rsp_valid_o;
    logic [2:0]  rsp_len_o;
    logic [55:0] rsp_data_o;
    logic        irq_n_o, bus_req_o, bus_auto_o;
    logic [7:0]  bus_cmd_o;
    logic [15:0] poll_mask_o;
    logic        dev_rsp_valid_i = 1'b0;
    logic [2:0]  dev_rsp_len_i = '0;
    logic [31:0] dev_rsp_data_i = '0;

    always #5 clk = ~clk;

    evt_irq_unit #(.POLL_CYCLES(P)) dut (.*);

    int checks = 0;
    int fails = 0;
    string cur_req = "R2";

    // behavioural reference model
    int   m_pend, m_mask, m_apm, m_cnt;
    bit   m_busy, m_kauto;
    byte  m_buf[$];
    bit   e_rv, e_req, e_auto, e_irq;
    int   e_rlen, e_cmd;
    byte  e_rsp[$];

    task automatic m_reset();
        m_pend = 0; m_mask = 'h81; m_apm = 0; m_cnt = 0;
        m_busy = 0; m_kauto = 0; m_buf.delete();
        e_rv = 0; e_req = 0; e_auto = 0; e_irq = 1; e_rlen = 0; e_cmd = 0;
        e_rsp.delete();
    endtask

    task automatic m_step();
        int set_b, clr_b, old_pend, old_apm, len;
        bit old_busy, restart, fire;
        byte a[4];
        for (int i = 0; i < 4; i++) a[i] = cmd_args_i[i*8 +: 8];
        old_pend = m_pend; old_apm = m_apm; old_busy = m_busy;
        e_rv = 0; e_req = 0; e_auto = 0; e_rlen = 0; e_cmd = 0; e_rsp.delete();
        set_b = int'(evt_i) << 2;
        if (tick_i) set_b |= 'h80;
        clr_b = 0;
        len = int'(cmd_len_i);
        if (cmd_valid_i) begin
            e_rv = 1;
            case (cmd_code_i)
                8'h10: if (len == 0) begin
                    if (m_pend & 1) begin
                        e_rsp.push_back(byte'(m_pend & 3));
                        foreach (m_buf[i]) e_rsp.push_back(m_buf[i]);
                        clr_b = 3; m_buf.delete();
                    end else begin
                        e_rsp.push_back(byte'(m_pend)); clr_b = 'hFF;
                    end
                    e_rlen = e_rsp.size();
                end
                8'h11: if (len == 1) m_mask = int'(a[0]) & 'hFF;
                8'h21: if (len == 0) m_apm = 0;
                8'h20: if (len >= 2) begin
                    if (a[0] == 0 && a[1] == 8'h86) begin
                        if (len == 4) m_apm = ((int'(a[2]) & 'hFF) << 8) | (int'(a[3]) & 'hFF);
                    end else if (len < 3 || (int'(a[2]) & 'hFF) > len - 3) begin
                        m_buf.delete(); m_buf.push_back(8'h00); set_b |= 1;
                    end else if (!m_busy) begin
                        e_req = 1; e_cmd = int'(a[0]) & 'hFF; m_busy = 1; m_kauto = 0;
                    end
                end
                default: ;
            endcase
        end
        if (dev_rsp_valid_i && old_busy) begin
            m_busy = 0;
            if (m_kauto) begin
                if (dev_rsp_len_i != 0) begin
                    m_buf.delete();
                    for (int i = 0; i < int'(dev_rsp_len_i); i++) m_buf.push_back(dev_rsp_data_i[i*8 +: 8]);
                    set_b |= 3;
                end
            end else begin
                m_buf.delete();
                if (dev_rsp_len_i != 0) begin
                    m_buf.push_back(8'h01); m_buf.push_back(byte'(dev_rsp_len_i));
                    for (int i = 0; i < int'(dev_rsp_len_i); i++) m_buf.push_back(dev_rsp_data_i[i*8 +: 8]);
                end else m_buf.push_back(8'h00);
                set_b |= 1;
            end
        end
        restart = (m_apm != old_apm);
        fire = (old_apm != 0) && (m_cnt == P - 1) && !restart && (m_apm != 0)
               && !(old_pend & 1) && !old_busy && !e_req;
        if (restart || old_apm == 0) m_cnt = 0;
        else m_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
        if (fire) begin
            e_req = 1; e_auto = 1; e_cmd = 0; m_busy = 1; m_kauto = 1;
        end
        m_pend = (m_pend & ~clr_b) | set_b;
        e_irq = ((m_pend & m_mask) == 0);
    endtask

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else m_step();
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [55:0] ed;
        ed = '0;
        foreach (e_rsp[i]) ed[i*8 +: 8] = e_rsp[i];
        chk("irq_n", 64'(irq_n_o), 64'(e_irq));
        chk("rsp_valid", 64'(rsp_valid_o), 64'(e_rv));
        chk("rsp_len", 64'(rsp_len_o), 64'(e_rlen));
        chk("rsp_data", 64'(rsp_data_o), 64'(ed));
        chk("bus_req", 64'({bus_req_o, bus_auto_o}), 64'({e_req, e_auto}));
        chk("bus_cmd", 64'(bus_cmd_o), 64'(e_cmd));
        chk("poll_mask", 64'(poll_mask_o), 64'(m_apm));
    end

    task automatic send(input logic [7:0] code, input int len, input logic [31:0] args);
        @(negedge clk);
        cmd_valid_i = 1'b1; cmd_code_i = code; cmd_len_i = 3'(len); cmd_args_i = args;
        @(negedge clk);
        cmd_valid_i = 1'b0; cmd_code_i = '0; cmd_len_i = '0; cmd_args_i = '0;
    endtask

    task automatic answer(input int len, input logic [31:0] data);
        dev_rsp_valid_i = 1'b1; dev_rsp_len_i = 3'(len); dev_rsp_data_i = data;
        @(negedge clk);
        dev_rsp_valid_i = 1'b0; dev_rsp_len_i = '0; dev_rsp_data_i = '0;
    endtask

    task automatic wait_req();
        bit seen = 0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            if (bus_req_o) seen = 1;
        end
        checks++;
        if (!seen) begin
            fails++;
            $display("FAIL %s bus request: actual 0 expected 1", cur_req);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                fails++;
                $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        cur_req = "R2";
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(3);

        cur_req = "R10";
        @(negedge clk); tick_i = 1'b1; evt_i = 5'b01001;
        @(negedge clk); tick_i = 1'b0; evt_i = '0;
        idle(2);

        cur_req = "R4";
        send(8'h10, 1, 32'h0);
        send(8'h10, 0, 32'h0);
        idle(2);

        cur_req = "R5";
        send(8'h11, 2, 32'h00FF);
        send(8'h11, 1, 32'h04);
        @(negedge clk); evt_i = 5'b00010;
        @(negedge clk); evt_i = '0;
        cur_req = "R1";
        @(negedge clk); evt_i = 5'b00001;
        @(negedge clk); evt_i = '0;
        send(8'h10, 0, 32'h0);
        send(8'h11, 1, 32'hFF);

        cur_req = "R10";
        @(negedge clk); tick_i = 1'b1; cmd_valid_i = 1'b1; cmd_code_i = 8'h10;
        @(negedge clk); tick_i = 1'b0; cmd_valid_i = 1'b0; cmd_code_i = '0;
        send(8'h10, 0, 32'h0);

        cur_req = "R9";
        send(8'h20, 1, 32'h0);
        send(8'h20, 3, 32'h05_2C);
        cur_req = "R3";
        send(8'h10, 0, 32'h0);
        cur_req = "R9";
        send(8'h20, 3, 32'h00_00_2C);
        answer(2, 32'hCD_AB);
        cur_req = "R3";
        send(8'h10, 0, 32'h0);
        cur_req = "R9";
        send(8'h20, 4, 32'h77_01_00_3C);
        answer(0, 32'h0);
        send(8'h10, 0, 32'h0);

        cur_req = "R7";
        send(8'h20, 3, 32'h05_86_00);
        send(8'h20, 4, 32'h05_00_86_00);
        cur_req = "R8";
        wait_req();
        answer(0, 32'h0);
        cur_req = "R6";
        wait_req();
        answer(3, 32'h33_22_11);
        idle(3 * P);
        cur_req = "R3";
        send(8'h10, 0, 32'h0);
        cur_req = "R8";
        send(8'h20, 4, 32'h05_00_86_00);
        wait_req();
        answer(1, 32'h5A);
        send(8'h10, 0, 32'h0);
        send(8'h20, 4, 32'h09_00_86_00);
        idle(P / 2);
        send(8'h21, 0, 32'h0);
        idle(3 * P);
        send(8'h20, 4, 32'h01_02_86_00);
        wait_req();
        answer(1, 32'h44);
        send(8'h20, 4, 32'h00_00_86_00);
        idle(3 * P);

        cur_req = "R11";
        send(8'h55, 2, 32'h1234);
        send(8'h21, 0, 32'h0);
        idle(3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule